// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Port with Two-Stage Clock Divider

This block is a 16-bit synchronous serial port that runs either as the bus master or as a slave. A register-style access point serves both data buffers. A write pulse loads the transmit buffer. The read data always shows the separate receive buffer, and a read pulse marks that buffer as consumed. Every transfer moves one whole 16-bit word through a single shift register, most significant bit first. The clock idles low: data changes after a falling edge and is sampled on a rising edge.

In master mode the block makes its own shift clock. The system clock first passes through a primary divider (1, 4, 16 or 64) and then through a secondary divider (1 to 8). The port starts a transfer as soon as the transmit buffer holds a word and the shift register is idle. In slave mode the shift clock, the active-low select and the serial input come from outside. Each of them passes through a two-flop synchroniser before its edges are used. When a word completes, it goes to the receive buffer. A word that arrives while the receive buffer is still unread is dropped, and an overflow flag records the loss.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset, tx_full, rx_full and rx_ovf are 0, rd_data is 0, sck_o is low, and sdo_oe is low in slave mode while ss_n_i is high.
- R2: wr_en stores wr_data and sets tx_full. In master mode with the shifter idle, the word moves into the shift register on the next clock and tx_full clears.
- R3: In master mode every high and every low phase of sck_o lasts P*S system clocks. P is 4 raised to cfg_div[1:0], which gives 1, 4, 16 or 64. S is 8 minus cfg_div[4:2], so 3'b111 gives 1 and 3'b000 gives 8.
- R4: A transfer is 16 bits, most significant bit first, with the clock idling low. sdo_o shows bit 15 as soon as the word is loaded and moves to the next bit after each falling edge. The serial input is sampled on each rising edge. After the 16th falling edge the received word holds the 16 samples, first sample in bit 15.
- R5: A completed word goes to rd_data and sets rx_full. rd_en clears rx_full.
- R6: If a word completes while rx_full is set and rd_en is low, the word is dropped, rd_data keeps the old word and rx_ovf sets. rx_ovf stays set until rd_en.
- R7: In slave mode the port shifts the transmit buffer out on sdo_o and captures sdi_i. It is clocked by the synchronised sck_i, with sdo_oe high while ss_n_i is low.
- R8: In slave mode, while ss_n_i is high, sdo_oe is low and sck_i edges are ignored. A transfer cut short by ss_n_i going high delivers no word, and the next select starts again at bit 15.
- R9: sck_oe equals cfg_master, and sck_o is low whenever no master transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_div | input | 5 | [1:0] primary divider select, [4:2] secondary divider select |
| wr_en | input | 1 | Write pulse to the transmit buffer |
| wr_data | input | 16 | Word to transmit |
| rd_en | input | 1 | Read pulse, consumes the receive buffer |
| rd_data | output | 16 | Receive buffer contents |
| tx_full | output | 1 | Transmit buffer holds a word not yet loaded |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_ovf | output | 1 | A received word was dropped |
| sck_i | input | 1 | Shift clock from an external master |
| sck_o | output | 1 | Shift clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_o |
| ss_n_i | input | 1 | Active-low select from an external master |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_o |

## Verification
The assertions check on every cycle that the clock stays low while the shifter is idle and that sdo_oe is off while a slave is deselected. They also check that an unread receive word holds steady, that the overflow flag is sticky, that a pending transmit word is taken by an idle master, and that the divider never sends two ticks in a row unless it divides by one. Only the bench scenarios can show the rest. That covers the phase lengths for all 32 divider settings and the bit order and data of complete words in both directions. It also covers discarding a partial slave transfer and the word that is kept when a second word arrives unread.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
  localparam int WORD_W = 16;
  localparam int PSEL_W = 2;
  localparam int SSEL_W = 3;

  typedef struct packed {
    logic [SSEL_W-1:0] sec;
    logic [PSEL_W-1:0] pri;
  } div_cfg_t;
endpackage

// File: rtl/spi_dm_prescale.sv
module spi_dm_prescale #(
  parameter int PSEL_W = 2,
  parameter int SSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PSEL_W-1:0] pri_sel,
  input  logic [SSEL_W-1:0] sec_sel,
  output logic              tick
);
  // primary count reaches 4^sel - 1; widest setting needs 2*(2^PSEL_W - 1) bits
  localparam int PCNT_W = 2 * ((1 << PSEL_W) - 1);

  logic [PCNT_W-1:0] pcnt, pri_lim;
  logic [SSEL_W-1:0] scnt, sec_lim;

  always_comb begin
    pri_lim = (PCNT_W'(1) << {pri_sel, 1'b0}) - PCNT_W'(1);
    sec_lim = ~sec_sel; // divide by 2^SSEL_W - sel
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      scnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pcnt == pri_lim) begin
        pcnt <= '0;
        if (scnt == sec_lim) begin
          scnt <= '0;
          tick <= 1'b1;
        end else begin
          scnt <= scnt + 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !(pri_sel == '0 && sec_sel == '1)) |=> !tick);
endmodule

// File: rtl/spi_dm_sync.sv
module spi_dm_sync #(
  parameter int            W       = 3,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_dm_shifter.sv
module spi_dm_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              sdi_bit,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] shreg
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitcnt;
  logic             samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
      samp   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy   <= 1'b0;
        bitcnt <= '0;
      end else if (load) begin
        busy   <= 1'b1;
        bitcnt <= '0;
        shreg  <= load_word;
      end else if (busy) begin
        if (rise_ev) samp <= sdi_bit;
        if (fall_ev) begin
          shreg  <= {shreg[WORD_W-2:0], samp};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  p_done_after_fall_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fall_ev && busy));
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_dm_pkg::*;
#(
  parameter int DW     = WORD_W,
  parameter int PSEL_W = spi_dm_pkg::PSEL_W,
  parameter int SSEL_W = spi_dm_pkg::SSEL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_master,
  input  logic [PSEL_W+SSEL_W-1:0] cfg_div,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  output logic [DW-1:0]            rd_data,
  output logic                     tx_full,
  output logic                     rx_full,
  output logic                     rx_ovf,
  input  logic                     sck_i,
  output logic                     sck_o,
  output logic                     sck_oe,
  input  logic                     ss_n_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  output logic                     sdo_oe
);
  logic [DW-1:0] tx_buf, shreg;
  logic          eng_busy, eng_done, load, abort, tick, sck_q;
  logic          rise_ev, fall_ev, sdi_bit;
  logic [2:0]    pin_s;
  logic          sck_s, ss_s, sdi_s, sck_p;
  logic [PSEL_W-1:0] pri_sel;
  logic [SSEL_W-1:0] sec_sel;

  assign pri_sel = cfg_div[PSEL_W-1:0];
  assign sec_sel = cfg_div[PSEL_W+SSEL_W-1:PSEL_W];

  spi_dm_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sdi_i, ss_n_i, sck_i}), .q(pin_s)
  );
  assign {sdi_s, ss_s, sck_s} = pin_s;

  always_ff @(posedge clk) begin
    if (rst) sck_p <= 1'b0;
    else     sck_p <= sck_s;
  end

  spi_dm_prescale #(.PSEL_W(PSEL_W), .SSEL_W(SSEL_W)) u_div (
    .clk(clk), .rst(rst), .run(cfg_master && eng_busy),
    .pri_sel(pri_sel), .sec_sel(sec_sel), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !cfg_master || !eng_busy) sck_q <= 1'b0;
    else if (tick)                       sck_q <= ~sck_q;
  end

  always_comb begin
    if (cfg_master) begin
      load    = tx_full && !eng_busy;
      abort   = 1'b0;
      rise_ev = tick && !sck_q;
      fall_ev = tick && sck_q;
      sdi_bit = sdi_i;
    end else begin
      load    = !ss_s && !eng_busy;
      abort   = ss_s;
      rise_ev = sck_s && !sck_p;
      fall_ev = !sck_s && sck_p;
      sdi_bit = sdi_s;
    end
  end

  spi_dm_shifter #(.WORD_W(DW)) u_shift (
    .clk(clk), .rst(rst), .abort(abort), .load(load), .load_word(tx_buf),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .sdi_bit(sdi_bit),
    .busy(eng_busy), .done(eng_done), .shreg(shreg)
  );

  // transmit side: a write wins over a simultaneous hand-off
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
    end else if (wr_en) begin
      tx_buf  <= wr_data;
      tx_full <= 1'b1;
    end else if (load) begin
      tx_full <= 1'b0;
    end
  end

  // receive side: a read in the same cycle frees room for the new word
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rx_full <= 1'b0;
      rx_ovf  <= 1'b0;
    end else begin
      if (rd_en) begin
        rx_full <= 1'b0;
        rx_ovf  <= 1'b0;
      end
      if (eng_done) begin
        if (!rx_full || rd_en) begin
          rd_data <= shreg;
          rx_full <= 1'b1;
        end else begin
          rx_ovf <= 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = cfg_master;
  assign sdo_o  = shreg[DW-1];
  assign sdo_oe = cfg_master || !ss_s;

  p_take_word_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && !eng_busy && tx_full && !wr_en) |=> !tx_full);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !sck_o);
  p_hold_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_en) |=> (rx_full && $stable(rd_data)));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf && !rd_en) |=> rx_ovf);
  p_hiz_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_master && ss_s) |-> !sdo_oe);
endmodule

// File: tb/spi_duplex_port_bench.sv
module spi_duplex_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_S     = 8;

  logic        clk = 1'b0, rst = 1'b1, cfg_master = 1'b0;
  logic [4:0]  cfg_div = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic        tx_full, rx_full, rx_ovf;
  logic        sck_i = 1'b0, ss_n_i = 1'b1, sck_o, sck_oe, sdo_o, sdo_oe;
  logic        m_sdi = 1'b0, s_sdi = 1'b0, sdi_i;
  int          nvec = 0, nfail = 0;
  bit          finished = 1'b0;

  assign sdi_i = cfg_master ? m_sdi : s_sdi;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_duplex_port u_spi_duplex_port (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tx_full(tx_full), .rx_full(rx_full), .rx_ovf(rx_ovf),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(ss_n_i),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  // master-side partner: captures sdo on rises, feeds sdi after falls
  bit          mon_on = 1'b0;
  logic        sck_prev = 1'b0;
  logic [15:0] cap = '0, rxpat = '0;
  int          hi = 0, lo = 0, sidx = 0, bad_w = 0, falls = 0, exp_half = 1;

  always @(negedge clk) begin
    if (mon_on) begin
      if (sck_o && !sck_prev) begin
        cap = {cap[14:0], sdo_o};
        if (falls > 0 && lo != exp_half) bad_w++;
        hi = 1;
      end else if (sck_o) hi++;
      else if (!sck_o && sck_prev) begin
        if (hi != exp_half) bad_w++;
        falls++;
        lo = 1;
        if (sidx > 0) begin sidx--; m_sdi = rxpat[sidx]; end
      end else lo++;
      sck_prev = sck_o;
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic slave_xfer(input logic [15:0] mosi, input int nbits, output logic [15:0] miso);
    miso = '0;
    @(negedge clk); ss_n_i = 1'b0;
    repeat (HALF_S) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      s_sdi = mosi[15-i];
      repeat (HALF_S) @(negedge clk);
      if (i == 0) chk("R7 sdo_oe selected", 32'(sdo_oe), 32'd1);
      miso = {miso[14:0], sdo_o};
      sck_i = 1'b1;
      repeat (HALF_S) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (HALF_S) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (HALF_S) @(negedge clk);
  endtask

  initial begin
    logic [15:0] txw, miso, mosi;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tx_full", 32'(tx_full), 0);
    chk("R1 rx_full", 32'(rx_full), 0);
    chk("R1 rx_ovf", 32'(rx_ovf), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 sck_o", 32'(sck_o), 0);
    chk("R1 sdo_oe", 32'(sdo_oe), 0);

    // master: sweep every primary/secondary divider pair
    cfg_master = 1'b1;
    @(negedge clk);
    chk("R9 sck_oe master", 32'(sck_oe), 1);
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++) begin
        int k, guard;
        k = p * 8 + s;
        cfg_div  = {3'(s), 2'(p)};
        exp_half = (1 << (2 * p)) * (8 - s);
        txw   = 16'h9D2B + 16'(k * 16'h03F1);
        rxpat = ~txw ^ {8'(k), 8'h5A};
        m_sdi = rxpat[15]; sidx = 15; cap = '0; bad_w = 0; falls = 0;
        hi = 0; lo = 0; sck_prev = 1'b0; mon_on = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_data = txw;
        @(negedge clk); wr_en = 1'b0;
        chk("R2 tx_full set", 32'(tx_full), 1);
        @(negedge clk);
        chk("R2 tx_full cleared on load", 32'(tx_full), 0);
        chk("R4 first bit msb", 32'(sdo_o), 32'(txw[15]));
        guard = 0;
        while (!rx_full && guard < 20000) begin @(negedge clk); guard++; end
        mon_on = 1'b0;
        chk("R4 sent word", 32'(cap), 32'(txw));
        chk("R4 received word", 32'(rd_data), 32'(rxpat));
        chk("R3 phase widths", 32'(bad_w), 0);
        chk("R4 edge count", 32'(falls), 16);
        chk("R9 sck idle low", 32'(sck_o), 0);
        chk("R5 rx_full set", 32'(rx_full), 1);
        rd();
        chk("R5 rx_full cleared", 32'(rx_full), 0);
      end
    end

    // slave mode
    @(negedge clk); cfg_master = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 sck_oe slave", 32'(sck_oe), 0);
    chk("R8 sdo_oe deselected", 32'(sdo_oe), 0);
    for (int k = 0; k < 16; k++) begin
      txw  = ~(16'h1 << k);
      mosi = (16'h1 << k) ^ 16'h6C93;
      wr(txw);
      chk("R2 tx_full slave", 32'(tx_full), 1);
      slave_xfer(mosi, 16, miso);
      chk("R7 slave sent", 32'(miso), 32'(txw));
      chk("R7 slave received", 32'(rd_data), 32'(mosi));
      chk("R5 rx_full slave", 32'(rx_full), 1);
      chk("R6 no overflow", 32'(rx_ovf), 0);
      rd();
    end

    // clock edges while deselected are ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sck_i = 1'b1;
      repeat (HALF_S) @(negedge clk); sck_i = 1'b0;
      repeat (HALF_S) @(negedge clk);
    end
    chk("R8 ignored edges rx_full", 32'(rx_full), 0);
    chk("R8 ignored edges sdo_oe", 32'(sdo_oe), 0);

    // partial transfer abandoned, then a clean one
    wr(16'hBEEF);
    slave_xfer(16'h1234, 5, miso);
    chk("R8 partial gives no word", 32'(rx_full), 0);
    wr(16'hC35A);
    slave_xfer(16'h7E81, 16, miso);
    chk("R8 restart at msb sent", 32'(miso), 32'hC35A);
    chk("R8 restart at msb received", 32'(rd_data), 32'h7E81);

    // overflow: second word with the first unread
    wr(16'h0FF0);
    slave_xfer(16'hA55A, 16, miso);
    chk("R6 overflow set", 32'(rx_ovf), 1);
    chk("R6 old word kept", 32'(rd_data), 32'h7E81);
    chk("R6 rx_full stays", 32'(rx_full), 1);
    rd();
    chk("R6 overflow cleared", 32'(rx_ovf), 0);
    chk("R6 rx_full cleared", 32'(rx_full), 0);

    summary();
  end
endmodule